// File: doc/BRIEF.md
# Table Lookup Source Selector

This block sits between a measurement converter and two output converters. It keeps two lookup tables of 64 rows each, one per output channel. Each table row holds an 8-bit converter code. On every clock each channel picks a row. Normally the row is the upper six bits of the 8-bit measurement. When the channel's index-select bit is set, a directly written six-bit index picks the row instead. The block then forms the row's memory address by adding a fixed per-table base (090h for the first table, 0D0h for the second). Addresses are nine bits wide because the second table reaches 10Fh.

Each channel can also be bypassed at the converter input. When its override-select bit is set, the channel code comes from a directly written 8-bit override byte, and the table row is not used. Table contents are loaded through a byte write port that uses the same address space. A lock level from the surrounding register bank can block writes to the first table or to both tables. Codes and addresses are registered outputs.

Top module: `tbl_src_sel`

## Requirements
- R1: When the index-select bit for a channel is 0 (bit 4 of `sel` for channel A, bit 6 for channel B), the row is `meas[7:2]`.
- R2: When the index-select bit is 1, the row is that channel's six-bit index input, and `meas` has no effect on that channel.
- R3: `taddr_a` equals 090h plus the channel A row and `taddr_b` equals 0D0h plus the channel B row, nine bits wide, so row 3Fh of table B gives 10Fh.
- R4: When the override-select bit is 0 (bit 5 of `sel` for A, bit 7 for B), the channel code is the content of the addressed row.
- R5: When the override-select bit is 1, the channel code is that channel's override byte, and the table row has no effect.
- R6: Codes and addresses change exactly one clock edge after their inputs change, and not before.
- R7: While `rst_n` is low, both codes are 00h, `taddr_a` is 090h, `taddr_b` is 0D0h, and every table row is cleared to 00h.
- R8: A write with `wr_en` high to an address inside a table's window (base to base+3Fh) stores `wr_data` in row address−base. Writes outside both windows change no row.
- R9: `lock_lvl` 0 or 1 leaves both tables writable, 2 blocks writes to table A only, and 3 blocks writes to both tables. A blocked write leaves the row unchanged.
- R10: When a write to the row being looked up falls in the same cycle as the lookup, the code registered at that edge holds the old row content. The new content appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas | input | 8 | Measurement byte |
| sel | input | 8 | Select register; bits 7..4 used, bits 3..0 unused |
| idx_a | input | 6 | Direct row index, channel A |
| idx_b | input | 6 | Direct row index, channel B |
| ovr_a | input | 8 | Override code, channel A |
| ovr_b | input | 8 | Override code, channel B |
| lock_lvl | input | 2 | Table write lock level |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 9 | Table write address |
| wr_data | input | 8 | Table write data |
| code_a | output | 8 | Registered converter code, channel A |
| code_b | output | 8 | Registered converter code, channel B |
| taddr_a | output | 9 | Registered table address, channel A |
| taddr_b | output | 9 | Registered table address, channel B |

## Verification
A table write and a table lookup can fall in the same cycle on the same row. The bench provokes this by pointing channel A at row 9 through its direct index. It then issues a write to 099h in the cycle that the lookup is captured. The code sampled after that edge must still show the old row value. The code sampled one cycle later must show the written byte.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [1:0] {
      LK_OPEN  = 2'd0,
      LK_MISC  = 2'd1,
      LK_TBL_A = 2'd2,
      LK_ALL   = 2'd3
   } lock_e;

   // select register bit positions: decoded by the register bank
   function automatic int idx_sel_bit(input int ch);
      return 4 + 2 * ch;
   endfunction

   function automatic int ovr_sel_bit(input int ch);
      return 5 + 2 * ch;
   endfunction

   // channel ch is locked once the level reaches ch + 2
   function automatic logic tbl_locked(input lock_e lv, input int ch);
      return (int'(lv) >= ch + 2);
   endfunction

endpackage

// File: rtl/tss_addr_gen.sv
module tss_addr_gen #(
   parameter int MEAS_W = 8,
   parameter int ROW_W  = 6,
   parameter int ADDR_W = 9,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic [MEAS_W-1:0] meas,
   input  logic [ROW_W-1:0]  idx,
   input  logic              use_idx,
   output logic [ROW_W-1:0]  row,
   output logic [ADDR_W-1:0] addr
);

   localparam int LSB_W = MEAS_W - ROW_W;

   if (ROW_W > MEAS_W) begin : g_bad_row
      $error("ROW_W must not exceed MEAS_W");
   end

   logic [ROW_W-1:0] meas_row;
   assign meas_row = meas[MEAS_W-1 -: ROW_W];

   if (LSB_W > 0) begin : g_lsb
      logic unused_meas_lsb;
      assign unused_meas_lsb = ^meas[LSB_W-1:0];
   end

   always_comb begin
      row  = use_idx ? idx : meas_row;
      addr = BASE + ADDR_W'(row);
   end

endmodule

// File: rtl/tss_table.sv
module tss_table #(
   parameter int ROW_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_allow,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ROW_W;

   if (DEPTH * DATA_W > 8192) begin : g_bad_size
      $error("table too large for flop storage");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
      end else if (wr_req && wr_allow) begin
         mem[wr_row] <= wr_data;
      end
   end

   assign rd_data = mem[rd_row];

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_allow) |=> (mem[$past(wr_row)] == $past(mem[wr_row])))
      else $error("blocked write changed a row"); // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_allow) |=> (mem[$past(wr_row)] == $past(wr_data)))
      else $error("allowed write not stored"); // R8

endmodule

// File: rtl/tbl_src_sel.sv
module tbl_src_sel #(
   parameter int MEAS_W = 8,
   parameter int ROW_W  = 6,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 9,
   parameter logic [ADDR_W-1:0] BASE_A = 9'h090,
   parameter logic [ADDR_W-1:0] BASE_B = 9'h0D0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MEAS_W-1:0] meas,
   input  logic [7:0]        sel,
   input  logic [ROW_W-1:0]  idx_a,
   input  logic [ROW_W-1:0]  idx_b,
   input  logic [CODE_W-1:0] ovr_a,
   input  logic [CODE_W-1:0] ovr_b,
   input  logic [1:0]        lock_lvl,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b,
   output logic [ADDR_W-1:0] taddr_a,
   output logic [ADDR_W-1:0] taddr_b
);
   import tss_pkg::*;

   localparam int NCH   = 2;
   localparam int DEPTH = 1 << ROW_W;

   if (int'(BASE_A) + DEPTH > (1 << ADDR_W) || int'(BASE_B) + DEPTH > (1 << ADDR_W)) begin : g_bad_base
      $error("table window exceeds address space");
   end
   if (int'(BASE_A) < int'(BASE_B) + DEPTH && int'(BASE_B) < int'(BASE_A) + DEPTH) begin : g_bad_overlap
      $error("table windows overlap");
   end

   logic unused_sel_lo;
   assign unused_sel_lo = ^sel[3:0];

   lock_e lock_q;
   assign lock_q = lock_e'(lock_lvl);

   logic [ROW_W-1:0]  idx_arr   [NCH];
   logic [CODE_W-1:0] ovr_arr   [NCH];
   logic [CODE_W-1:0] code_q    [NCH];
   logic [ADDR_W-1:0] taddr_q   [NCH];

   assign idx_arr[0] = idx_a;
   assign idx_arr[1] = idx_b;
   assign ovr_arr[0] = ovr_a;
   assign ovr_arr[1] = ovr_b;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = (c == 0) ? BASE_A : BASE_B;
      localparam int IDX_BIT = idx_sel_bit(c);
      localparam int OVR_BIT = ovr_sel_bit(c);

      logic              use_idx, use_ovr;
      logic [ROW_W-1:0]  row;
      logic [ADDR_W-1:0] addr;
      logic [ADDR_W-1:0] wr_off;
      logic              wr_hit;
      logic [CODE_W-1:0] row_data;

      assign use_idx = sel[IDX_BIT];
      assign use_ovr = sel[OVR_BIT];
      assign wr_off  = wr_addr - BASE;
      assign wr_hit  = wr_en && (wr_off < ADDR_W'(DEPTH));

      tss_addr_gen #(
         .MEAS_W (MEAS_W),
         .ROW_W  (ROW_W),
         .ADDR_W (ADDR_W),
         .BASE   (BASE)
      ) u_addr (
         .meas    (meas),
         .idx     (idx_arr[c]),
         .use_idx (use_idx),
         .row     (row),
         .addr    (addr)
      );

      tss_table #(
         .ROW_W  (ROW_W),
         .DATA_W (CODE_W)
      ) u_tbl (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_req   (wr_hit),
         .wr_allow (!tbl_locked(lock_q, c)),
         .wr_row   (wr_off[ROW_W-1:0]),
         .wr_data  (wr_data),
         .rd_row   (row),
         .rd_data  (row_data)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[c]  <= '0;
            taddr_q[c] <= BASE;
         end else begin
            code_q[c]  <= use_ovr ? ovr_arr[c] : row_data;
            taddr_q[c] <= addr;
         end
      end

      AST_ROW_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(sel[IDX_BIT]))
         |-> (taddr_q[c] == BASE + ADDR_W'($past(meas[MEAS_W-1 -: ROW_W]))))
         else $error("row not taken from measurement"); // R1

      AST_ROW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(sel[IDX_BIT]))
         |-> (taddr_q[c] == BASE + ADDR_W'($past(idx_arr[c]))))
         else $error("row not taken from index"); // R2

      AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
         (ADDR_W'(taddr_q[c] - BASE) < ADDR_W'(DEPTH)))
         else $error("address outside table window"); // R3

      AST_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(sel[OVR_BIT])) |-> (code_q[c] == $past(ovr_arr[c])))
         else $error("override not passed"); // R5
   end

   assign code_a  = code_q[0];
   assign code_b  = code_q[1];
   assign taddr_a = taddr_q[0];
   assign taddr_b = taddr_q[1];

endmodule

// File: tb/tb_tbl_src_sel.sv
`timescale 1ns/1ps
module tb_tbl_src_sel;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] meas = '0;
   logic [7:0] sel = '0;
   logic [5:0] idx_a = '0, idx_b = '0;
   logic [7:0] ovr_a = '0, ovr_b = '0;
   logic [1:0] lock_lvl = '0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] code_a, code_b;
   logic [8:0] taddr_a, taddr_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tbl_src_sel dut (
      .clk(clk), .rst_n(rst_n), .meas(meas), .sel(sel),
      .idx_a(idx_a), .idx_b(idx_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
      .lock_lvl(lock_lvl), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .code_a(code_a), .code_b(code_b), .taddr_a(taddr_a), .taddr_b(taddr_b)
   );

   // {sel[7:4], meas, idx_a, idx_b, ovr_a, ovr_b, exp taddr_a, exp taddr_b, exp code_a, exp code_b}
   // table A row r holds 40h+r, table B row r holds 80h+r
   localparam int NV = 9;
   localparam logic [73:0] VEC [NV] = '{
      {4'b0000, 8'h00, 6'h00, 6'h00, 8'h00, 8'h00, 9'h090, 9'h0D0, 8'h40, 8'h80},
      {4'b0000, 8'hFF, 6'h00, 6'h00, 8'h00, 8'h00, 9'h0CF, 9'h10F, 8'h7F, 8'hBF},
      {4'b0000, 8'h57, 6'h00, 6'h00, 8'h00, 8'h00, 9'h0A5, 9'h0E5, 8'h55, 8'h95},
      {4'b0001, 8'h57, 6'h2A, 6'h00, 8'h00, 8'h00, 9'h0BA, 9'h0E5, 8'h6A, 8'h95},
      {4'b0100, 8'h04, 6'h00, 6'h3F, 8'h00, 8'h00, 9'h091, 9'h10F, 8'h41, 8'hBF},
      {4'b0010, 8'h80, 6'h00, 6'h00, 8'h5C, 8'h00, 9'h0B0, 9'h0F0, 8'h5C, 8'hA0},
      {4'b1000, 8'h80, 6'h00, 6'h00, 8'h00, 8'hE7, 9'h0B0, 9'h0F0, 8'h60, 8'hE7},
      {4'b1111, 8'hFF, 6'h01, 6'h02, 8'h11, 8'h22, 9'h091, 9'h0D2, 8'h11, 8'h22},
      {4'b0101, 8'hFF, 6'h00, 6'h3F, 8'h00, 8'h00, 9'h090, 9'h10F, 8'h40, 8'hBF}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tbl_write(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R7: reset state
      repeat (2) @(negedge clk);
      chk("R7 code_a", 16'(code_a), 16'h00);
      chk("R7 code_b", 16'(code_b), 16'h00);
      chk("R7 taddr_a", 16'(taddr_a), 16'h090);
      chk("R7 taddr_b", 16'(taddr_b), 16'h0D0);
      rst_n = 1'b1;
      @(negedge clk);
      meas = 8'hFF;
      @(negedge clk);
      chk("R7 cleared row B3F", 16'(code_b), 16'h00);

      // R8: fill both tables
      for (int r = 0; r < 64; r++) tbl_write(9'h090 + 9'(r), 8'h40 + 8'(r));
      for (int r = 0; r < 64; r++) tbl_write(9'h0D0 + 9'(r), 8'h80 + 8'(r));

      // vector table: R1 R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         sel   = {VEC[v][73:70], 4'b0000};
         meas  = VEC[v][69:62];
         idx_a = VEC[v][61:56];
         idx_b = VEC[v][55:50];
         ovr_a = VEC[v][49:42];
         ovr_b = VEC[v][41:34];
         @(negedge clk);
         chk("R1/R2/R3 taddr_a", 16'(taddr_a), 16'(VEC[v][33:25]));
         chk("R1/R2/R3 taddr_b", 16'(taddr_b), 16'(VEC[v][24:16]));
         chk("R4/R5 code_a", 16'(code_a), 16'(VEC[v][15:8]));
         chk("R4/R5 code_b", 16'(code_b), 16'(VEC[v][7:0]));
      end

      // R6: no change before the edge, change after it
      @(negedge clk);
      sel = 8'h00; meas = 8'h10;
      @(negedge clk);
      chk("R6 settled code_a", 16'(code_a), 16'h44);
      meas = 8'h20;
      #1;
      chk("R6 before edge code_a", 16'(code_a), 16'h44);
      chk("R6 before edge taddr_a", 16'(taddr_a), 16'h094);
      @(negedge clk);
      chk("R6 after edge code_a", 16'(code_a), 16'h48);

      // R8: writes outside both windows change nothing
      tbl_write(9'h08F, 8'h33);
      tbl_write(9'h110, 8'h33);
      meas = 8'h00;
      @(negedge clk);
      chk("R8 out-of-window A row0", 16'(code_a), 16'h40);
      meas = 8'hFF;
      @(negedge clk);
      chk("R8 out-of-window B row3F", 16'(code_b), 16'hBF);

      // R9: lock levels
      sel = 8'h50; idx_a = 6'd5; idx_b = 6'd5;
      lock_lvl = 2'd2;
      tbl_write(9'h095, 8'hEE);
      tbl_write(9'h0D5, 8'hDD);
      @(negedge clk);
      chk("R9 level2 blocks A", 16'(code_a), 16'h45);
      chk("R9 level2 allows B", 16'(code_b), 16'hDD);
      lock_lvl = 2'd3; idx_b = 6'd6;
      tbl_write(9'h0D6, 8'hCC);
      @(negedge clk);
      chk("R9 level3 blocks B", 16'(code_b), 16'h86);
      lock_lvl = 2'd1; idx_a = 6'd7;
      tbl_write(9'h097, 8'h77);
      @(negedge clk);
      chk("R9 level1 allows A", 16'(code_a), 16'h77);
      lock_lvl = 2'd0;

      // R10: write and lookup of the same row in one cycle
      idx_a = 6'd9;
      @(negedge clk);
      chk("R10 before write", 16'(code_a), 16'h49);
      wr_en = 1'b1; wr_addr = 9'h099; wr_data = 8'h99;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 same-cycle old value", 16'(code_a), 16'h49);
      @(negedge clk);
      chk("R10 next-cycle new value", 16'(code_a), 16'h99);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule